// File: doc/BRIEF.md
# ECC Write-Path Fault Injector

This block sits on the write path between a memory controller's ECC encoder and the RAM write port. The encoder's finished codeword (64 data bits and 8 check bits) passes through it in the same cycle, together with its write strobe. When software has armed an injection mode, the block flips one or two chosen codeword bits before the word reaches the array. Later reads of that location then raise a correctable or a non-correctable ECC event. The check bits are always computed on the true data, so the corruption behaves like a real storage fault.

Software uses a 16-bit control register to arm the block. It has four mode enables and a 7-bit position field. Each of the two fault kinds has a continuous mode and a one-shot mode: single-bit faults invert one bit, and non-correctable faults invert two adjacent bits. A one-shot mode re-arms only when software clears its enable and then sets it again. An enable can be set only while the external correction-reporting enable input is high.

Top module: `ecc_wr_injector`

## Requirements
- R1: After reset the control register reads 0x0000, and every codeword write passes through unchanged.
- R2: Register layout, with bit 15 as the MSB: bit 13 is continuous single, bit 12 is one-shot single, bit 9 is continuous double, bit 8 is one-shot double, and bits 6:0 are the position. Bits 15, 14, 11, 10 and 7 always read 0, so writing 0xFFFF reads back 0x337F. The register keeps its value when it is not written.
- R3: A register write can set bits 13, 12, 9 and 8 only while `corr_rpt_en` is high. If `corr_rpt_en` is low, those bits are stored as 0, while the position field is still written. Writing 0 to an enable always clears it.
- R4: While continuous single is set, every strobed codeword has the bit at the selected position inverted.
- R5: One-shot single corrupts only the first strobed write after its enable changes from 0 to 1. Later writes pass unchanged. Writing 1 over a 1 does not re-arm the mode; clearing the enable and setting it again does.
- R6: The double modes, continuous and one-shot, invert the selected position and the position (p+1) mod 72. So position 71 flips bits 71 and 0.
- R7: When a double mode and a single mode are both armed, only the double pattern is applied. A one-shot is used up only by a strobed write that applies its own pattern. An armed one-shot single survives a write that a double mode corrupts, and it survives any number of idle cycles.
- R8: Position values 72 to 127 invert nothing. A one-shot armed with such a position is still used up by the next strobed write.
- R9: `cw_wr_out` equals `cw_wr_in`, and `cw_out` is produced combinationally in the same cycle. At most two bits ever differ from `cw_in`, and none differ when the strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctl_wr_en | input | 1 | Control register write enable |
| ctl_wdata | input | 16 | Control register write data |
| ctl_rdata | output | 16 | Control register read data |
| corr_rpt_en | input | 1 | Correction-reporting enable; gates the setting of mode bits |
| cw_in | input | 72 | Encoded codeword from the ECC encoder |
| cw_wr_in | input | 1 | Write strobe for `cw_in` |
| cw_out | output | 72 | Codeword to the RAM write port |
| cw_wr_out | output | 1 | Write strobe to the RAM write port |

## Verification
The codeword path is exercised with several data patterns: all zeros, all ones, alternating bits and a mixed word. A wrong bit position therefore shows up as a flip from 0 to 1 or from 1 to 0, and cannot hide behind the data. Positions 5, 10, 66 (a check bit), 71 and 72/127 separate:
- correct decoding of the field,
- the wrap of the double pattern,
- the out-of-range case.

Sequences of repeated writes, idle gaps, rewrites of 1 over 1 and clear-then-set tell one-shot behaviour apart from continuous behaviour. A mixed arming, with one-shot single and continuous double set together, shows the priority and that an unapplied one-shot is kept.

// File: rtl/ecc_inj_pkg.sv
package ecc_inj_pkg;
  localparam int CTL_W   = 16;
  localparam int POS_W   = 7;
  localparam int N_MODES = 4;

  // mode indices
  localparam int M_CONT_SGL = 0;
  localparam int M_ONCE_SGL = 1;
  localparam int M_CONT_DBL = 2;
  localparam int M_ONCE_DBL = 3;

  // register bit holding each mode enable (LSB = bit 0)
  localparam int MODE_BIT [N_MODES] = '{13, 12, 9, 8};

  localparam logic [CTL_W-1:0] ENA_MASK = 16'h3300;
  localparam logic [CTL_W-1:0] WR_MASK  = 16'h337F;

  typedef enum logic [1:0] {
    INJ_NONE = 2'd0,
    INJ_SGL  = 2'd1,
    INJ_DBL  = 2'd2
  } inj_kind_e;
endpackage

// File: rtl/ecc_inj_rst_sync.sv
module ecc_inj_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/ecc_inj_ctrl.sv
module ecc_inj_ctrl
  import ecc_inj_pkg::*;
(
  input  logic               clk,
  input  logic               srst_n,
  input  logic               wr_en,
  input  logic [CTL_W-1:0]   wdata,
  input  logic               rpt_en,
  input  logic               fire_once_sgl,
  input  logic               fire_once_dbl,
  output logic [CTL_W-1:0]   ctl,
  output logic [N_MODES-1:0] armed
);
  logic [CTL_W-1:0]   ctl_q, ctl_d;
  logic [N_MODES-1:0] arm_q, arm_d, fire;

  // next register value: enables are gated by the reporting enable
  always_comb begin
    ctl_d = ctl_q;
    if (wr_en) ctl_d = wdata & WR_MASK & ~(rpt_en ? '0 : ENA_MASK);
  end

  assign fire = {fire_once_dbl, 1'b0, fire_once_sgl, 1'b0};

  for (genvar m = 0; m < N_MODES; m++) begin : g_arm
    localparam int B = MODE_BIT[m];
    logic rise;
    assign rise     = wr_en & ~ctl_q[B] & ctl_d[B];
    assign arm_d[m] = !ctl_d[B] ? 1'b0 :
                      rise      ? 1'b1 :
                                  (arm_q[m] & ~fire[m]);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ctl_q <= '0;
      arm_q <= '0;
    end else begin
      if (wr_en)              ctl_q <= ctl_d;
      if (wr_en || (|fire))   arm_q <= arm_d;
    end
  end

  assign ctl   = ctl_q;
  assign armed = arm_q;
endmodule

// File: rtl/ecc_inj_mask.sv
module ecc_inj_mask
  import ecc_inj_pkg::*;
#(
  parameter int CW_W = 72
) (
  input  inj_kind_e         kind,
  input  logic [POS_W-1:0]  pos,
  output logic [CW_W-1:0]   mask
);
  for (genvar i = 0; i < CW_W; i++) begin : g_bit
    localparam int PREV = (i == 0) ? CW_W - 1 : i - 1;
    assign mask[i] = ((kind != INJ_NONE) && (pos == POS_W'(i))) ||
                     ((kind == INJ_DBL)  && (pos == POS_W'(PREV)));
  end
endmodule

// File: rtl/ecc_wr_injector.sv
module ecc_wr_injector
  import ecc_inj_pkg::*;
#(
  parameter  int DATA_W = 64,
  parameter  int CHK_W  = 8,
  localparam int CW_W   = DATA_W + CHK_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr_en,
  input  logic [15:0]      ctl_wdata,
  output logic [15:0]      ctl_rdata,
  input  logic             corr_rpt_en,
  input  logic [CW_W-1:0]  cw_in,
  input  logic             cw_wr_in,
  output logic [CW_W-1:0]  cw_out,
  output logic             cw_wr_out
);
  logic               srst_n;
  logic [CTL_W-1:0]   ctl;
  logic [N_MODES-1:0] armed;
  logic               dbl_on, sgl_on;
  logic               fire_once_sgl, fire_once_dbl;
  inj_kind_e          kind;
  logic [CW_W-1:0]    mask;

  ecc_inj_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  ecc_inj_ctrl u_ctrl (
    .clk           (clk),
    .srst_n        (srst_n),
    .wr_en         (ctl_wr_en),
    .wdata         (ctl_wdata),
    .rpt_en        (corr_rpt_en),
    .fire_once_sgl (fire_once_sgl),
    .fire_once_dbl (fire_once_dbl),
    .ctl           (ctl),
    .armed         (armed)
  );

  assign dbl_on = armed[M_CONT_DBL] | armed[M_ONCE_DBL];
  assign sgl_on = armed[M_CONT_SGL] | armed[M_ONCE_SGL];

  // double pattern wins; a one-shot is spent only when its pattern is applied
  always_comb begin
    kind = INJ_NONE;
    if (cw_wr_in) begin
      if (dbl_on)      kind = INJ_DBL;
      else if (sgl_on) kind = INJ_SGL;
    end
  end

  assign fire_once_dbl = cw_wr_in & armed[M_ONCE_DBL];
  assign fire_once_sgl = cw_wr_in & armed[M_ONCE_SGL] & ~dbl_on;

  ecc_inj_mask #(.CW_W(CW_W)) u_mask (
    .kind (kind),
    .pos  (ctl[POS_W-1:0]),
    .mask (mask)
  );

  assign cw_out    = cw_in ^ mask;
  assign cw_wr_out = cw_wr_in;
  assign ctl_rdata = ctl;
endmodule

// File: rtl/ecc_inj_chk.sv
module ecc_inj_chk #(
  parameter int CW_W = 72
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ctl_wr_en,
  input logic [15:0]     ctl_rdata,
  input logic            corr_rpt_en,
  input logic [CW_W-1:0] cw_in,
  input logic            cw_wr_in,
  input logic [CW_W-1:0] cw_out
);
  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata & 16'hCC80) == 16'h0000);

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr_en |=> $stable(ctl_rdata));

  // R3
  gated_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr_en && !corr_rpt_en) |=> ((ctl_rdata & 16'h3300) == 16'h0000));

  // R5
  oneshot_spent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_wr_in && (cw_out != cw_in) && ctl_rdata[12] && !ctl_rdata[13] &&
     !ctl_rdata[9] && !ctl_rdata[8] && !ctl_wr_en)
    |=> (!cw_wr_in || (cw_out == cw_in)));

  // R9
  flip_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cw_out ^ cw_in) <= 2);

  // R9
  idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cw_wr_in |-> (cw_out == cw_in));
endmodule

bind ecc_wr_injector ecc_inj_chk #(.CW_W(CW_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ctl_wr_en   (ctl_wr_en),
  .ctl_rdata   (ctl_rdata),
  .corr_rpt_en (corr_rpt_en),
  .cw_in       (cw_in),
  .cw_wr_in    (cw_wr_in),
  .cw_out      (cw_out)
);

// File: tb/test_ecc_wr_injector.sv
module test_ecc_wr_injector;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 72;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ctl_wr_en;
  logic [15:0]   ctl_wdata;
  logic [15:0]   ctl_rdata;
  logic          corr_rpt_en;
  logic [CW-1:0] cw_in;
  logic          cw_wr_in;
  logic [CW-1:0] cw_out;
  logic          cw_wr_out;

  int checks = 0;
  int errors = 0;

  logic [CW-1:0] exp_q[$];
  string         tag_q[$];

  localparam logic [CW-1:0] P0 = '0;
  localparam logic [CW-1:0] P1 = '1;
  localparam logic [CW-1:0] P2 = {9{8'hA5}};
  localparam logic [CW-1:0] P3 = {8'hC3, 64'h0123_4567_89AB_CDEF};

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_wr_injector i_ecc_wr_injector (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_wr_en   (ctl_wr_en),
    .ctl_wdata   (ctl_wdata),
    .ctl_rdata   (ctl_rdata),
    .corr_rpt_en (corr_rpt_en),
    .cw_in       (cw_in),
    .cw_wr_in    (cw_wr_in),
    .cw_out      (cw_out),
    .cw_wr_out   (cw_wr_out)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic reg_wr(input logic [15:0] v, input logic rpt);
    ctl_wr_en = 1'b1; ctl_wdata = v; corr_rpt_en = rpt;
    tick();
    ctl_wr_en = 1'b0; corr_rpt_en = 1'b1;
  endtask

  task automatic rd_chk(input logic [15:0] exp, input string tag);
    checks++;
    if (ctl_rdata !== exp) begin
      errors++;
      $display("FAIL %s: ctl_rdata got %h exp %h", tag, ctl_rdata, exp);
    end
  endtask

  // driver: pushes the expected codeword, then strobes it for one cycle
  task automatic cw_wr(input logic [CW-1:0] d, input int p1, input int p2,
                       input string tag);
    logic [CW-1:0] e;
    e = d;
    if (p1 >= 0) e[p1] = ~e[p1];
    if (p2 >= 0) e[p2] = ~e[p2];
    exp_q.push_back(e);
    tag_q.push_back(tag);
    cw_in = d; cw_wr_in = 1'b1;
    tick();
    cw_wr_in = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      tick();
      checks++;
      if (cw_wr_out !== 1'b0 || cw_out !== cw_in) begin
        errors++;
        $display("FAIL R9: idle strobe %b data %h exp strobe 0 data %h",
                 cw_wr_out, cw_out, cw_in);
      end
    end
  endtask

  // monitor: compares each strobed output against the scoreboard
  always @(negedge clk) begin
    if (rst_n === 1'b1 && cw_wr_out === 1'b1) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R9: unexpected write %h exp none", cw_out);
      end else begin
        logic [CW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (cw_out !== e) begin
          errors++;
          $display("FAIL %s: cw_out got %h exp %h", t, cw_out, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ctl_wr_en = 1'b0; ctl_wdata = '0; corr_rpt_en = 1'b1;
    cw_in = '0; cw_wr_in = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(3);

    // R1 reset state
    rd_chk(16'h0000, "R1");
    cw_wr(P3, -1, -1, "R1");

    // R2 layout, all modes armed with out-of-range position (R8)
    reg_wr(16'hFFFF, 1'b1);
    rd_chk(16'h337F, "R2");
    cw_wr(P1, -1, -1, "R8");
    reg_wr(16'h0000, 1'b1);
    rd_chk(16'h0000, "R3");

    // R3 enables blocked while reporting is off
    reg_wr(16'h3307, 1'b0);
    rd_chk(16'h0007, "R3");
    cw_wr(P2, -1, -1, "R3");

    // R4 continuous single
    reg_wr(16'h2005, 1'b1);
    cw_wr(P0, 5, -1, "R4");
    cw_wr(P1, 5, -1, "R4");
    reg_wr(16'h2047, 1'b1);
    cw_wr(P2, 71, -1, "R4");
    reg_wr(16'h2042, 1'b1);
    cw_wr(P3, 66, -1, "R4");
    reg_wr(16'h0042, 1'b0);
    rd_chk(16'h0042, "R3");
    cw_wr(P0, -1, -1, "R3");

    // R5 one-shot single, R7 survives idle cycles
    reg_wr(16'h100A, 1'b1);
    idle(3);
    cw_wr(P1, 10, -1, "R7");
    cw_wr(P2, -1, -1, "R5");
    reg_wr(16'h100A, 1'b1);
    cw_wr(P3, -1, -1, "R5");
    rd_chk(16'h100A, "R5");
    reg_wr(16'h000A, 1'b1);
    reg_wr(16'h100A, 1'b1);
    cw_wr(P0, 10, -1, "R5");

    // R6 double modes
    reg_wr(16'h0000, 1'b1);
    reg_wr(16'h0247, 1'b1);
    cw_wr(P1, 71, 0, "R6");
    cw_wr(P2, 71, 0, "R6");
    reg_wr(16'h0000, 1'b1);
    reg_wr(16'h0103, 1'b1);
    cw_wr(P3, 3, 4, "R6");
    cw_wr(P0, -1, -1, "R6");

    // R7 priority, unapplied one-shot kept
    reg_wr(16'h0000, 1'b1);
    reg_wr(16'h1209, 1'b1);
    cw_wr(P1, 9, 10, "R7");
    reg_wr(16'h1009, 1'b1);
    cw_wr(P2, 9, -1, "R7");
    cw_wr(P3, -1, -1, "R5");

    // R8 out-of-range positions
    reg_wr(16'h0000, 1'b1);
    reg_wr(16'h2048, 1'b1);
    cw_wr(P0, -1, -1, "R8");
    reg_wr(16'h207F, 1'b1);
    cw_wr(P2, -1, -1, "R8");
    reg_wr(16'h0000, 1'b1);
    reg_wr(16'h1048, 1'b1);
    cw_wr(P1, -1, -1, "R8");
    reg_wr(16'h1003, 1'b1);
    cw_wr(P2, -1, -1, "R8");

    idle(2);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R9: pending writes got %0d exp 0", exp_q.size());
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule